// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 9-bit first-in first-out buffer. Its write side and its read side run on clocks that have no relation to each other. Data is stored in an internal dual-port array that holds a power-of-two number of words, 4096 by default. Four active-low status flags report how full the buffer is:

- `ef_n` (empty) and `pae_n` (almost empty) belong to the read clock.
- `full_n` (full) and `paf_n` (almost full) belong to the write clock.

The read data bus can be put into a high-impedance state.

One input, `wen2_ld`, takes on one of two roles. The block samples it while reset is held, and the sampled value fixes the role until the next reset.

- **Dual-enable mode** (`wen2_ld` high during reset): the pin acts as a second, active-high write enable.
- **Offset mode** (`wen2_ld` low during reset): the pin acts as a load strobe. While it is low, a write or a read reaches the two threshold registers instead of the data array. This is how software sets and reads back the almost-empty and almost-full margins over the normal data buses.

Pointers cross between the two clock domains as Gray codes through two-stage synchronisers. For that reason, a flag may leave its asserted state a few destination-clock cycles late. A flag never asserts late.

Top module: `dcfifo_pf`

## Requirements
- R1: While `rst` is high (sampled on each side's own clock), the pointers clear, `ef_n` and `pae_n` go low, and `full_n` and `paf_n` go high. Both threshold registers return to 7, and both offset selectors clear.
- R2: Words leave in the order they entered. A read happens only on a `rclk` rising edge where `ren1_n` and `ren2_n` are both low. `q` shows the read word after that same edge.
- R3: In dual-enable mode, a word is stored only on a `wclk` edge where `wen1_n` is low and `wen2_ld` is high. Any other combination stores nothing.
- R4: In offset mode, with `wen2_ld` high, `wen1_n` low alone stores data. With `wen2_ld` low, a write loads `din` into a threshold register, and a read with both read enables low puts a threshold value on `q`.
- R5: A write while `full_n` is low is dropped. A read while `ef_n` is low is dropped, and `q` keeps its previous value.
- R6: Once both clocks have run idle for several cycles, `pae_n` is low exactly when the stored count is at or below the almost-empty threshold. `paf_n` is low exactly when the free space is at or below the almost-full threshold.
- R7: Threshold accesses alternate: the first goes to almost-empty, the next to almost-full, then almost-empty again. The write side and the read side each keep their own selector.
- R8: While `oe_n` is high, `q` is high-impedance.
- R9: Flags never show more room or more data than exists. `ef_n` high implies at least one stored word, and `full_n` high implies the count is below the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable or threshold load strobe, role fixed at reset |
| din | input | 9 | Write data or threshold value |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable for `q` |
| q | output | 9 | Read data or threshold readback, three-state |
| ef_n | output | 1 | Empty flag, active low, read clock |
| pae_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| paf_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
The two functions that can fall in the same moment are a write on `wclk` and a read on `rclk`. Each moves its own pointer while the other side's copy of that pointer is still in transit through a synchroniser.

This is provoked by running both streams together with unrelated clock periods and random enable patterns. One run starts near empty and another near full, so both the empty and the full boundary are crossed repeatedly.

Every read is judged against a queue model. On every clock, the flags are judged one-sidedly against the model's count: `ef_n` may show empty late but never early, and `full_n` likewise.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/100ps
package dcfifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  // Which register currently feeds the read bus
  typedef enum logic {SRC_RAM = 1'b0, SRC_THR = 1'b1} rd_src_e;
endpackage

// File: rtl/dcfifo_ram.sv
`timescale 1ns/100ps
module dcfifo_ram
  import dcfifo_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int WORDS = 1 << AW;

  word_t mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_gray_sync.sv
`timescale 1ns/100ps
module dcfifo_gray_sync #(
  parameter int W = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/100ps
module dcfifo_pf
  import dcfifo_pkg::*;
#(
  parameter int          DEPTH       = 4096,
  parameter logic [8:0]  THR_DEFAULT = 9'd7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst,
  input  logic       wen1_n,
  input  logic       wen2_ld,
  input  logic [8:0] din,
  input  logic       ren1_n,
  input  logic       ren2_n,
  input  logic       oe_n,
  output logic [8:0] q,
  output logic       ef_n,
  output logic       pae_n,
  output logic       full_n,
  output logic       paf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW:0]   DEPTH_X  = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  // ---------------- write clock domain ----------------
  logic          thr_mode_w, wsel;
  word_t         ae_thr, af_thr;
  logic [PW-1:0] wbin, wgray, wbin_nx, rgray_s, rbin_s, wcnt_nx;
  logic [PW:0]   wfree_x;
  logic          wr_thr, wr_data;

  assign wr_thr  = !wen1_n && thr_mode_w && !wen2_ld;
  assign wr_data = !wen1_n && wen2_ld && full_n;
  assign wbin_nx = wbin + PW'(wr_data);

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wcnt_nx = wbin_nx - rbin_s;
  assign wfree_x = DEPTH_X - {1'b0, wcnt_nx};

  always_ff @(posedge wclk) begin
    if (rst) begin
      thr_mode_w <= !wen2_ld;
      wbin       <= '0;
      wgray      <= '0;
      full_n     <= 1'b1;
      paf_n      <= 1'b1;
      wsel       <= 1'b0;
      ae_thr     <= THR_DEFAULT;
      af_thr     <= THR_DEFAULT;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_n <= (wcnt_nx != FULL_CNT);
      paf_n  <= (wfree_x > {{(PW-8){1'b0}}, af_thr});
      if (wr_thr) begin
        wsel <= !wsel;
        if (!wsel) ae_thr <= din;
        else       af_thr <= din;
      end
    end
  end

  // ---------------- read clock domain ----------------
  logic          thr_mode_r, rsel;
  rd_src_e       src;
  word_t         thr_q, ram_q;
  logic [PW-1:0] rbin, rgray, rbin_nx, wgray_s, wbin_s, rcnt_nx;
  logic          rd_thr, rd_data;

  assign rd_thr  = !ren1_n && !ren2_n && thr_mode_r && !wen2_ld;
  assign rd_data = !ren1_n && !ren2_n && !rd_thr && ef_n;
  assign rbin_nx = rbin + PW'(rd_data);

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign rcnt_nx = wbin_s - rbin_nx;

  always_ff @(posedge rclk) begin
    if (rst) begin
      thr_mode_r <= !wen2_ld;
      rbin       <= '0;
      rgray      <= '0;
      ef_n       <= 1'b0;
      pae_n      <= 1'b0;
      rsel       <= 1'b0;
      src        <= SRC_RAM;
      thr_q      <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      ef_n  <= (rcnt_nx != '0);
      pae_n <= ({1'b0, rcnt_nx} > {{(PW-8){1'b0}}, ae_thr});
      if (rd_thr) begin
        rsel  <= !rsel;
        thr_q <= rsel ? af_thr : ae_thr;
        src   <= SRC_THR;
      end else if (rd_data) begin
        src   <= SRC_RAM;
      end
    end
  end

  // ---------------- storage and crossings ----------------
  dcfifo_ram #(.AW(AW)) ram_i (
    .wclk(wclk), .we(wr_data), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .re(rd_data), .raddr(rbin[AW-1:0]), .rdata(ram_q)
  );

  dcfifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcfifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  assign q = oe_n ? 'z : ((src == SRC_THR) ? thr_q : ram_q);

  // ---------------- assertions ----------------
  // R1
  wr_reset_chk: assert property (@(posedge wclk) disable iff (rst)
    $fell(rst) |-> (full_n && paf_n));
  // R1
  rd_reset_chk: assert property (@(posedge rclk) disable iff (rst)
    $fell(rst) |-> (!ef_n && !pae_n));
  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
    !full_n |=> (wbin == $past(wbin)));
  // R5
  no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
    !ef_n |=> (rbin == $past(rbin)));
  // R9
  count_bound_chk: assert property (@(posedge wclk) disable iff (rst)
    (wbin - rbin_s) <= FULL_CNT);
  // R6
  empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (rst)
    !ef_n |-> !pae_n);
  // R7
  wsel_toggle_chk: assert property (@(posedge wclk) disable iff (rst)
    wr_thr |=> (wsel != $past(wsel)));
  // R7
  rsel_toggle_chk: assert property (@(posedge rclk) disable iff (rst)
    rd_thr |=> (rsel != $past(rsel)));
endmodule

// File: tb/dcfifo_pf_tb_top.sv
`timescale 1ns/100ps
module dcfifo_pf_tb_top;
  localparam int DEPTH = 256;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] q;
  logic ef_n, pae_n, full_n, paf_n;

  int errs = 0, checks = 0;
  logic [8:0] model [$];
  logic [8:0] last_q = '0;
  int wcount = 0;

  always #2.5 wclk = ~wclk;   // 200 MHz
  always #3.5 rclk = ~rclk;   // unrelated read clock

  dcfifo_pf #(.DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q(q),
    .ef_n(ef_n), .pae_n(pae_n), .full_n(full_n), .paf_n(paf_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9: flags never report more data or more room than the model holds
  always @(negedge rclk) if (!rst && ef_n) begin
    checks++;
    if (model.size() == 0) begin
      errs++;
      $display("FAIL R9 ef_n actual=1 expected=0 (model empty)");
    end
  end
  always @(negedge wclk) if (!rst && full_n) begin
    checks++;
    if (model.size() >= DEPTH) begin
      errs++;
      $display("FAIL R9 full_n actual=1 expected=0 (count=%0d)", model.size());
    end
  end

  task automatic do_reset(bit role_hi);
    @(negedge wclk);
    rst = 1'b1; wen2_ld = role_hi; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    rst = 1'b0;
    model.delete();
    repeat (3) @(posedge rclk);
  endtask

  task automatic wr(logic [8:0] d, bit w2, output bit took);
    @(negedge wclk);
    din = d; wen2_ld = w2; wen1_n = 1'b0;
    took = w2 && full_n;
    @(posedge wclk);
    if (took) model.push_back(d);
    #0.5 wen1_n = 1'b1;
  endtask

  task automatic wr_n(int n);
    bit t;
    for (int i = 0; i < n; i++) begin
      wr(9'(wcount), 1'b1, t);
      wcount++;
    end
  endtask

  task automatic rd_chk(string tag, output bit took);
    logic [8:0] exp;
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    took = ef_n;
    @(posedge rclk);
    #0.5 ren1_n = 1'b1; ren2_n = 1'b1;
    if (took) begin
      if (model.size() == 0) begin
        checks++; errs++;
        $display("FAIL %s read with empty model actual=%0d expected=none", tag, q);
      end else begin
        exp = model.pop_front();
        chk(tag, int'(q), int'(exp));
        last_q = q;
      end
    end
  endtask

  task automatic rd_thr(int exp, string tag);
    @(negedge rclk);
    wen2_ld = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(posedge rclk);
    #0.5 ren1_n = 1'b1; ren2_n = 1'b1;
    chk(tag, int'(q), exp);
    wen2_ld = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    #0.5;
  endtask

  task automatic stress(int n, int wr_pct, int rd_pct);
    fork
      begin
        bit t;
        for (int i = 0; i < n; i++) begin
          wr(9'(wcount), ($urandom % 100) < wr_pct, t);
          wcount++;
        end
      end
      begin
        bit t;
        for (int i = 0; i < n; i++) begin
          if (($urandom % 100) < rd_pct) rd_chk("R2 stream", t);
          else @(negedge rclk);
        end
      end
    join
  endtask

  initial begin
    #900us;
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit t;
    // ---------- dual-enable mode ----------
    do_reset(1'b1);
    chk("R1 ef_n", ef_n, 0);
    chk("R1 pae_n", pae_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 paf_n", paf_n, 1);

    wr(9'h155, 1'b0, t);          // R3: second enable low, nothing stored
    settle();
    chk("R3 ef_n after gated write", ef_n, 0);

    wr_n(7);
    settle();
    chk("R6 ef_n at 7", ef_n, 1);
    chk("R6 pae_n at 7 words", pae_n, 0);
    wr_n(1);
    settle();
    chk("R6 pae_n at 8 words", pae_n, 1);
    wr_n(240);
    settle();
    chk("R6 paf_n free 8", paf_n, 1);
    wr_n(1);
    settle();
    chk("R6 paf_n free 7", paf_n, 0);
    wr_n(7);
    settle();
    chk("R5 full_n at depth", full_n, 0);
    wr(9'h1aa, 1'b1, t);
    chk("R5 write while full accepted", t, 0);

    // R2: a single read enable does not read
    @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b1;
    @(posedge rclk); #0.5 ren1_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) rd_chk("R2 ordered drain", t);
    settle();
    chk("R5 ef_n after drain", ef_n, 0);
    chk("R5 model empty after drain", model.size(), 0);
    rd_chk("R5 empty read", t);
    chk("R5 empty read taken", t, 0);
    chk("R5 q held on empty read", int'(q), int'(last_q));

    oe_n = 1'b1; #1;
    chk("R8 q high-Z", (q === 9'bzzzzzzzzz), 1);
    oe_n = 1'b0; #1;
    chk("R8 q driven", int'(q), int'(last_q));

    // ---------- concurrent streams ----------
    stress(600, 60, 70);
    stress(1200, 90, 35);
    settle();
    for (int i = 0; i < 2 * DEPTH; i++) if (model.size() > 0) rd_chk("R2 final drain", t);
    chk("R2 stream fully drained", model.size(), 0);

    // ---------- offset mode ----------
    do_reset(1'b0);
    chk("R1 ef_n in offset mode", ef_n, 0);
    rd_thr(7, "R1 default almost-empty threshold");
    rd_thr(7, "R1 default almost-full threshold");
    do_reset(1'b0);
    wr(9'd3, 1'b0, t);
    wr(9'd5, 1'b0, t);
    settle();
    chk("R4 threshold write stores no data", ef_n, 0);
    rd_thr(3, "R7 first access almost-empty");
    rd_thr(5, "R7 second access almost-full");
    rd_thr(3, "R7 wraps to almost-empty");
    wr_n(3);
    settle();
    chk("R4 data write with wen1_n only", ef_n, 1);
    chk("R6 pae_n at 3 words thr 3", pae_n, 0);
    wr_n(1);
    settle();
    chk("R6 pae_n at 4 words thr 3", pae_n, 1);
    rd_chk("R4 data read in offset mode", t);
    chk("R4 read taken", t, 1);
    wr_n(247);
    settle();
    chk("R6 paf_n free 6 thr 5", paf_n, 1);
    wr_n(1);
    settle();
    chk("R6 paf_n free 5 thr 5", paf_n, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule